// File: doc/BRIEF.md
# Control Endpoint Transfer Sequencer

This block is the hardware sequencer for the default control pipe of a USB device. It reads each SETUP packet, decides which kind of request it carries, and then runs the data and status stages of the transfer without software help. Descriptor reads are served from an external table: the sequencer presents a lookup key and gets back a hit flag and a size. It then emits one or more send-packet commands, each with a length and a byte offset into that descriptor. The packet buffer logic uses those commands to move the bytes. The storage itself lies outside the block.

Two standard requests are completed locally: address assignment and configuration selection. The new device address is committed only once the zero-length status packet has gone out, so the status handshake still completes at the old address. A bus reset returns the address to zero with the enable set and re-arms reception. Any request the sequencer does not recognise is handed off on a strobe. A watchdog of fixed length stalls the endpoint if no acknowledge comes back in time.

Top module: `ctrl_ep_seq`

## Requirements
- R1: A SETUP packet whose length is not 8 bytes raises `ep_stall` in the following cycle and produces no `tx_send`.
- R2: A SETUP packet with request type 0x80, 0x81 or 0x82 and request code 6 starts a descriptor lookup. The key is wIndex on `desc_index` and wValue on `desc_value`. Setup bytes are little-endian: byte 0 is the type, byte 1 is the code, bytes 2-3 are wValue, bytes 4-5 are wIndex and bytes 6-7 are wLength, with byte 0 in `setup_bytes[7:0]`. If the lookup misses, the endpoint stalls and no packet is sent. Any other type with code 6 is not a descriptor read.
- R3: On a lookup hit, the reply length is min(wLength, `desc_size`). The first packet is sent with offset 0.
- R4: No sent packet is longer than MAX_PKT bytes. Each `in_done` during the data stage sends the next chunk at the running offset until all reply bytes have been sent.
- R5: The `in_done` that follows the last data packet pulses `rx_arm` and sends nothing more. In the status-receive stage, a zero-length OUT pulses `rx_arm`. An OUT of nonzero length stalls the endpoint.
- R6: Request type 0x00 with code 5 sends a zero-length packet. `dev_addr` keeps its old value until the following `in_done`. At that point `dev_addr` takes wValue[6:0], `addr_en` is 1 and `rx_arm` pulses.
- R7: Request type 0x00 with code 9 pulses `cfg_strobe` with wValue on `cfg_value` and sends a zero-length packet. Completing its status stage leaves `dev_addr` unchanged.
- R8: Any other valid request pulses `handoff_req`. A `handoff_done` within TIMEOUT_CYC cycles sends a zero-length packet. Without it, the endpoint stalls after TIMEOUT_CYC cycles and nothing is sent.
- R9: `bus_reset` sets `dev_addr` to 0 with `addr_en` 1, clears `ep_stall`, pulses `rx_arm` and abandons any transfer.
- R10: After `rst`, `dev_addr` is 0, `addr_en` is 0, `ep_stall` is 0 and no strobe is active.
- R11: A valid SETUP packet clears a stall left by an earlier request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset event (one-cycle pulse) |
| setup_rx | input | 1 | SETUP packet received (pulse) |
| setup_len | input | PKT_W (7) | Byte count of the SETUP packet |
| setup_bytes | input | 64 | The eight setup bytes, byte 0 in [7:0] |
| out_rx | input | 1 | OUT packet received (pulse) |
| out_len | input | PKT_W (7) | Byte count of the OUT packet |
| in_done | input | 1 | IN packet transmitted (pulse) |
| desc_index | output | 16 | Lookup key, wIndex |
| desc_value | output | 16 | Lookup key, wValue |
| desc_found | input | 1 | Lookup hit, sampled one cycle after the key is presented |
| desc_size | input | 16 | Descriptor size on a hit |
| tx_send | output | 1 | Send-packet command (pulse) |
| tx_len | output | PKT_W (7) | Length of the packet to send |
| tx_offset | output | 16 | Byte offset of the packet within the reply |
| rx_arm | output | 1 | Re-arm reception as valid (pulse) |
| ep_stall | output | 1 | Endpoint stalled (level) |
| dev_addr | output | 7 | Device address register |
| addr_en | output | 1 | Address enable |
| cfg_strobe | output | 1 | Configuration selected (pulse) |
| cfg_value | output | 16 | Selected configuration index |
| handoff_req | output | 1 | Unrecognised request handed off (pulse) |
| held_setup | output | 64 | Latched setup bytes of the current request |
| handoff_done | input | 1 | Acknowledge of a handed-off request |

## Verification
The assertions assume that `bus_reset`, `setup_rx`, `out_rx`, `in_done` and `handoff_done` are single-cycle pulses. They also assume that `in_done` arrives only after a packet was actually commanded, and that the descriptor table answers in the cycle after the key appears. The address-stability property relies on `dev_addr` changing only at an `in_done` or a bus reset, so no other event may move it. The bench raises each event for exactly one cycle with the others idle. It returns `desc_found` and `desc_size` combinationally from the presented key, and it issues `in_done` and status OUT packets only in the stage that expects them.

// File: rtl/ctrl_ep_pkg.sv
`timescale 1ns/100ps
package ctrl_ep_pkg;

    localparam logic [7:0] RT_STD_OUT      = 8'h00;
    localparam logic [7:0] RT_IN_DEVICE    = 8'h80;
    localparam logic [7:0] RT_IN_IFACE     = 8'h81;
    localparam logic [7:0] RT_IN_ENDPOINT  = 8'h82;
    localparam logic [7:0] RC_GET_DESC     = 8'd6;
    localparam logic [7:0] RC_SET_ADDRESS  = 8'd5;
    localparam logic [7:0] RC_SET_CONFIG   = 8'd9;
    localparam int         SETUP_BYTES     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_DATA_TX,
        ST_STATUS_RX,
        ST_STATUS_TX,
        ST_HANDOFF
    } seq_state_t;

    typedef enum logic [1:0] {
        REQ_GET_DESC,
        REQ_SET_ADDR,
        REQ_SET_CFG,
        REQ_OTHER
    } req_kind_t;

    typedef struct packed {
        logic [15:0] length;
        logic [15:0] index;
        logic [15:0] value;
        logic [7:0]  code;
        logic [7:0]  rtype;
    } setup_pkt_t;

    // Little-endian byte image to fields; byte 0 sits in bits [7:0].
    function automatic setup_pkt_t unpack_setup(input logic [63:0] raw);
        setup_pkt_t p;
        p.rtype  = raw[7:0];
        p.code   = raw[15:8];
        p.value  = raw[31:16];
        p.index  = raw[47:32];
        p.length = raw[63:48];
        return p;
    endfunction

    function automatic req_kind_t classify(input logic [7:0] rtype, input logic [7:0] code);
        if ((rtype == RT_IN_DEVICE || rtype == RT_IN_IFACE || rtype == RT_IN_ENDPOINT)
            && code == RC_GET_DESC)
            return REQ_GET_DESC;
        if (rtype == RT_STD_OUT && code == RC_SET_ADDRESS)
            return REQ_SET_ADDR;
        if (rtype == RT_STD_OUT && code == RC_SET_CONFIG)
            return REQ_SET_CFG;
        return REQ_OTHER;
    endfunction

endpackage

// File: rtl/ctrl_setup_decode.sv
`timescale 1ns/100ps
module ctrl_setup_decode
    import ctrl_ep_pkg::*;
#(
    parameter int PKT_W = 7
) (
    input  logic [63:0]      setup_bytes,
    input  logic [PKT_W-1:0] setup_len,
    output req_kind_t        kind,
    output logic             len_ok
);
    setup_pkt_t pkt;

    always_comb begin
        pkt    = unpack_setup(setup_bytes);
        kind   = classify(pkt.rtype, pkt.code);
        len_ok = (setup_len == PKT_W'(SETUP_BYTES));
    end
endmodule

// File: rtl/ctrl_chunker.sv
`timescale 1ns/100ps
module ctrl_chunker #(
    parameter int MAX_PKT = 64,
    parameter int LEN_W   = 16,
    localparam int PKT_W  = $clog2(MAX_PKT + 1)
) (
    input  logic [LEN_W-1:0] remaining,
    output logic [PKT_W-1:0] pkt_len,
    output logic [LEN_W-1:0] rest
);
    always_comb begin
        if (remaining > LEN_W'(MAX_PKT))
            pkt_len = PKT_W'(MAX_PKT);
        else
            pkt_len = remaining[PKT_W-1:0];
        rest = remaining - LEN_W'(pkt_len);
    end
endmodule

// File: rtl/ctrl_handoff_timer.sv
`timescale 1ns/100ps
module ctrl_handoff_timer #(
    parameter int TIMEOUT_CYC = 1000,
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != CNT_W'(TIMEOUT_CYC))
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CNT_W'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/ctrl_ep_seq.sv
`timescale 1ns/100ps
module ctrl_ep_seq
    import ctrl_ep_pkg::*;
#(
    parameter int  MAX_PKT     = 64,
    parameter int  TIMEOUT_CYC = 1000,
    localparam int PKT_W       = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset,
    input  logic             setup_rx,
    input  logic [PKT_W-1:0] setup_len,
    input  logic [63:0]      setup_bytes,
    input  logic             out_rx,
    input  logic [PKT_W-1:0] out_len,
    input  logic             in_done,
    output logic [15:0]      desc_index,
    output logic [15:0]      desc_value,
    input  logic             desc_found,
    input  logic [15:0]      desc_size,
    output logic             tx_send,
    output logic [PKT_W-1:0] tx_len,
    output logic [15:0]      tx_offset,
    output logic             rx_arm,
    output logic             ep_stall,
    output logic [6:0]       dev_addr,
    output logic             addr_en,
    output logic             cfg_strobe,
    output logic [15:0]      cfg_value,
    output logic             handoff_req,
    output logic [63:0]      held_setup,
    input  logic             handoff_done
);
    localparam int LEN_W = 16;

    seq_state_t       st;
    logic [63:0]      setup_raw_q;
    setup_pkt_t       held;
    req_kind_t        in_kind;
    logic             in_len_ok;
    logic [LEN_W-1:0] reply_total;
    logic [LEN_W-1:0] remaining_q;
    logic [LEN_W-1:0] offset_q;
    logic [LEN_W-1:0] first_rest;
    logic [LEN_W-1:0] next_rest;
    logic [PKT_W-1:0] first_len;
    logic [PKT_W-1:0] next_len;
    logic             wait_run;
    logic             wait_expired;
    logic             addr_request;

    assign held        = unpack_setup(setup_raw_q);
    assign held_setup  = setup_raw_q;
    assign desc_index  = held.index;
    assign desc_value  = held.value;
    assign cfg_value   = held.value;
    assign reply_total = (held.length < desc_size) ? held.length : desc_size;
    assign wait_run    = (st == ST_HANDOFF);
    assign addr_request = (held.rtype == RT_STD_OUT) && (held.code == RC_SET_ADDRESS);

    ctrl_setup_decode #(.PKT_W(PKT_W)) u_decode (
        .setup_bytes (setup_bytes),
        .setup_len   (setup_len),
        .kind        (in_kind),
        .len_ok      (in_len_ok)
    );

    // First chunk of a reply and every following chunk each get their own sizing path.
    ctrl_chunker #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) u_first_chunk (
        .remaining (reply_total),
        .pkt_len   (first_len),
        .rest      (first_rest)
    );

    ctrl_chunker #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) u_next_chunk (
        .remaining (remaining_q),
        .pkt_len   (next_len),
        .rest      (next_rest)
    );

    ctrl_handoff_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .run     (wait_run),
        .expired (wait_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            setup_raw_q <= '0;
            remaining_q <= '0;
            offset_q    <= '0;
            tx_send     <= 1'b0;
            tx_len      <= '0;
            tx_offset   <= '0;
            rx_arm      <= 1'b0;
            ep_stall    <= 1'b0;
            dev_addr    <= '0;
            addr_en     <= 1'b0;
            cfg_strobe  <= 1'b0;
            handoff_req <= 1'b0;
        end else begin
            tx_send     <= 1'b0;
            rx_arm      <= 1'b0;
            cfg_strobe  <= 1'b0;
            handoff_req <= 1'b0;

            if (bus_reset) begin
                st          <= ST_IDLE;
                dev_addr    <= '0;
                addr_en     <= 1'b1;
                ep_stall    <= 1'b0;
                rx_arm      <= 1'b1;
                remaining_q <= '0;
                offset_q    <= '0;
            end else if (setup_rx) begin
                setup_raw_q <= setup_bytes;
                ep_stall    <= 1'b0;
                remaining_q <= '0;
                offset_q    <= '0;
                if (!in_len_ok) begin
                    ep_stall <= 1'b1;
                    st       <= ST_IDLE;
                end else begin
                    case (in_kind)
                        REQ_GET_DESC: st <= ST_LOOKUP;
                        REQ_SET_ADDR: begin
                            tx_send   <= 1'b1;
                            tx_len    <= '0;
                            tx_offset <= '0;
                            st        <= ST_STATUS_TX;
                        end
                        REQ_SET_CFG: begin
                            cfg_strobe <= 1'b1;
                            tx_send    <= 1'b1;
                            tx_len     <= '0;
                            tx_offset  <= '0;
                            st         <= ST_STATUS_TX;
                        end
                        default: begin
                            handoff_req <= 1'b1;
                            st          <= ST_HANDOFF;
                        end
                    endcase
                end
            end else begin
                case (st)
                    ST_LOOKUP: begin
                        if (!desc_found) begin
                            ep_stall <= 1'b1;
                            st       <= ST_IDLE;
                        end else begin
                            tx_send     <= 1'b1;
                            tx_len      <= first_len;
                            tx_offset   <= '0;
                            remaining_q <= first_rest;
                            offset_q    <= LEN_W'(first_len);
                            st          <= ST_DATA_TX;
                        end
                    end
                    ST_DATA_TX: begin
                        if (in_done) begin
                            if (remaining_q != '0) begin
                                tx_send     <= 1'b1;
                                tx_len      <= next_len;
                                tx_offset   <= offset_q;
                                remaining_q <= next_rest;
                                offset_q    <= offset_q + LEN_W'(next_len);
                            end else begin
                                rx_arm <= 1'b1;
                                st     <= ST_STATUS_RX;
                            end
                        end
                    end
                    ST_STATUS_RX: begin
                        if (out_rx) begin
                            if (out_len != '0)
                                ep_stall <= 1'b1;
                            else
                                rx_arm <= 1'b1;
                            st <= ST_IDLE;
                        end
                    end
                    ST_STATUS_TX: begin
                        if (in_done) begin
                            if (addr_request) begin
                                dev_addr <= held.value[6:0];
                                addr_en  <= 1'b1;
                            end
                            rx_arm <= 1'b1;
                            st     <= ST_IDLE;
                        end
                    end
                    ST_HANDOFF: begin
                        if (handoff_done) begin
                            tx_send   <= 1'b1;
                            tx_len    <= '0;
                            tx_offset <= '0;
                            st        <= ST_STATUS_TX;
                        end else if (wait_expired) begin
                            ep_stall <= 1'b1;
                            st       <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ctrl_ep_seq_chk.sv
`timescale 1ns/100ps
module ctrl_ep_seq_chk
    import ctrl_ep_pkg::*;
#(
    parameter int  MAX_PKT     = 64,
    parameter int  TIMEOUT_CYC = 1000,
    localparam int PKT_W       = $clog2(MAX_PKT + 1),
    localparam int HC_W        = $clog2(TIMEOUT_CYC + 2)
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_reset,
    input logic             setup_rx,
    input logic [PKT_W-1:0] setup_len,
    input logic             out_rx,
    input logic [PKT_W-1:0] out_len,
    input logic             in_done,
    input logic             tx_send,
    input logic [PKT_W-1:0] tx_len,
    input logic             rx_arm,
    input logic             ep_stall,
    input logic [6:0]       dev_addr,
    input logic             addr_en,
    input seq_state_t       st
);
    logic [HC_W-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst || st != ST_HANDOFF)
            hcnt <= '0;
        else if (hcnt != HC_W'(TIMEOUT_CYC + 1))
            hcnt <= hcnt + 1'b1;
    end

    p_bad_setup_stall_r1: assert property (@(posedge clk) disable iff (rst)
        (setup_rx && setup_len != PKT_W'(8) && !bus_reset) |=> (ep_stall && !tx_send));

    p_pkt_limit_r4: assert property (@(posedge clk) disable iff (rst)
        tx_send |-> (tx_len <= PKT_W'(MAX_PKT)));

    p_bad_status_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STATUS_RX && out_rx && out_len != '0 && !setup_rx && !bus_reset) |=> ep_stall);

    p_addr_deferred_r6: assert property (@(posedge clk) disable iff (rst)
        (!in_done && !bus_reset) |=> $stable(dev_addr));

    p_handoff_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HANDOFF) |-> (hcnt < HC_W'(TIMEOUT_CYC)));

    p_bus_reset_r9: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (dev_addr == '0 && addr_en && rx_arm && !ep_stall));
endmodule

bind ctrl_ep_seq ctrl_ep_seq_chk #(.MAX_PKT(MAX_PKT), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (.*);

// File: tb/tb_ctrl_ep_seq.sv
`timescale 1ns/100ps
module tb_ctrl_ep_seq;
    localparam int MAX_PKT = 64;
    localparam int TMO     = 16;
    localparam int PKT_W   = $clog2(MAX_PKT + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_reset = 1'b0;
    logic             setup_rx = 1'b0;
    logic [PKT_W-1:0] setup_len = '0;
    logic [63:0]      setup_bytes = '0;
    logic             out_rx = 1'b0;
    logic [PKT_W-1:0] out_len = '0;
    logic             in_done = 1'b0;
    logic [15:0]      desc_index, desc_value;
    logic             desc_found;
    logic [15:0]      desc_size;
    logic             tx_send;
    logic [PKT_W-1:0] tx_len;
    logic [15:0]      tx_offset;
    logic             rx_arm, ep_stall, addr_en, cfg_strobe, handoff_req;
    logic [6:0]       dev_addr;
    logic [15:0]      cfg_value;
    logic [63:0]      held_setup;
    logic             handoff_done = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int n_send = 0, n_arm = 0, n_cfg = 0, n_hand = 0;
    int last_len = -1, last_off = -1;

    always #2.5 clk = ~clk;

    ctrl_ep_seq #(.MAX_PKT(MAX_PKT), .TIMEOUT_CYC(TMO)) dut (.*);

    // Descriptor table model: two entries keyed on (wIndex, wValue).
    always_comb begin
        desc_found = 1'b0;
        desc_size  = 16'd0;
        if (desc_index == 16'h0000 && desc_value == 16'h0100) begin
            desc_found = 1'b1;
            desc_size  = 16'd18;
        end else if (desc_index == 16'h0000 && desc_value == 16'h0200) begin
            desc_found = 1'b1;
            desc_size  = 16'd150;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_send) begin
                n_send++;
                last_len = int'(tx_len);
                last_off = int'(tx_offset);
            end
            if (rx_arm) n_arm++;
            if (cfg_strobe) n_cfg++;
            if (handoff_req) n_hand++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_setup(input logic [7:0] rt, input logic [7:0] code, input logic [15:0] val,
                              input logic [15:0] idx, input logic [15:0] wlen, input int blen);
        @(negedge clk);
        setup_rx    = 1'b1;
        setup_len   = PKT_W'(blen);
        setup_bytes = {wlen, idx, val, code, rt};
        @(negedge clk);
        setup_rx = 1'b0;
    endtask

    task automatic pulse_in();
        @(negedge clk);
        in_done = 1'b1;
        @(negedge clk);
        in_done = 1'b0;
    endtask

    task automatic pulse_out(input int len);
        @(negedge clk);
        out_rx  = 1'b1;
        out_len = PKT_W'(len);
        @(negedge clk);
        out_rx = 1'b0;
    endtask

    task automatic pulse_bus_reset();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    task automatic t_reset_state();
        check(dev_addr == 0, "R10 addr", dev_addr, 0);
        check(addr_en == 0, "R10 addr_en", addr_en, 0);
        check(ep_stall == 0, "R10 stall", ep_stall, 0);
        check(n_send + n_arm + n_cfg + n_hand == 0, "R10 strobes", n_send + n_arm + n_cfg + n_hand, 0);
    endtask

    task automatic t_bus_reset();
        int a0 = n_arm;
        pulse_bus_reset();
        idle(2);
        check(dev_addr == 0 && addr_en == 1, "R9 addr/en", {dev_addr, addr_en}, 1);
        check(n_arm == a0 + 1, "R9 rx_arm", n_arm, a0 + 1);
    endtask

    task automatic t_short_setup();
        int s0 = n_send;
        send_setup(8'h80, 8'd6, 16'h0100, 16'h0000, 16'd64, 7);
        idle(4);
        check(ep_stall == 1, "R1 stall", ep_stall, 1);
        check(n_send == s0, "R1 no send", n_send, s0);
    endtask

    task automatic t_desc_small();
        int s0 = n_send;
        int a0;
        send_setup(8'h80, 8'd6, 16'h0100, 16'h0000, 16'd64, 8);
        idle(4);
        check(ep_stall == 0, "R11 stall cleared", ep_stall, 0);
        check(n_send == s0 + 1, "R2 hit sends", n_send, s0 + 1);
        check(last_len == 18 && last_off == 0, "R3 len=size", last_len, 18);
        a0 = n_arm;
        pulse_in();
        idle(3);
        check(n_arm == a0 + 1 && n_send == s0 + 1, "R5 status armed", n_arm, a0 + 1);
        pulse_out(0);
        idle(3);
        check(n_arm == a0 + 2 && ep_stall == 0, "R5 zero status", n_arm, a0 + 2);
    endtask

    task automatic t_desc_trunc();
        send_setup(8'h80, 8'd6, 16'h0100, 16'h0000, 16'd10, 8);
        idle(4);
        check(last_len == 10, "R3 len=wLength", last_len, 10);
        pulse_in();
        idle(2);
        pulse_out(0);
        idle(2);
    endtask

    task automatic t_desc_chunks();
        int s0 = n_send;
        int a0;
        send_setup(8'h81, 8'd6, 16'h0200, 16'h0000, 16'd200, 8);
        idle(4);
        check(last_len == 64 && last_off == 0, "R4 chunk0", last_len, 64);
        pulse_in();
        idle(3);
        check(last_len == 64 && last_off == 64, "R4 chunk1 off", last_off, 64);
        a0 = n_arm;
        pulse_in();
        idle(3);
        check(last_len == 22 && last_off == 128, "R4 chunk2 len", last_len, 22);
        check(n_arm == a0, "R4 not yet armed", n_arm, a0);
        pulse_in();
        idle(3);
        check(n_send == s0 + 3 && n_arm == a0 + 1, "R5 after last", n_send, s0 + 3);
        pulse_out(3);
        idle(3);
        check(ep_stall == 1, "R5 nonzero status stall", ep_stall, 1);
    endtask

    task automatic t_desc_miss();
        int s0 = n_send;
        send_setup(8'h82, 8'd6, 16'h0300, 16'h0000, 16'd64, 8);
        idle(4);
        check(ep_stall == 1, "R2 miss stall", ep_stall, 1);
        check(n_send == s0, "R2 miss no send", n_send, s0);
    endtask

    task automatic t_wrong_type_get();
        int h0 = n_hand;
        int s0 = n_send;
        send_setup(8'h00, 8'd6, 16'h0100, 16'h0000, 16'd64, 8);
        idle(4);
        check(n_hand == h0 + 1 && n_send == s0, "R2 type 0x00 not lookup", n_hand, h0 + 1);
        idle(TMO + 4);
    endtask

    task automatic t_set_addr();
        int s0 = n_send;
        int a0;
        send_setup(8'h00, 8'd5, 16'h002A, 16'h0000, 16'd0, 8);
        idle(4);
        check(n_send == s0 + 1 && last_len == 0, "R6 zlp", last_len, 0);
        check(dev_addr == 0, "R6 addr held before status", dev_addr, 0);
        a0 = n_arm;
        pulse_in();
        idle(3);
        check(dev_addr == 7'h2A && addr_en == 1, "R6 addr applied", dev_addr, 42);
        check(n_arm == a0 + 1, "R6 rx_arm", n_arm, a0 + 1);
    endtask

    task automatic t_set_cfg();
        int s0 = n_send;
        int c0 = n_cfg;
        send_setup(8'h00, 8'd9, 16'h0003, 16'h0000, 16'd0, 8);
        idle(4);
        check(n_cfg == c0 + 1 && cfg_value == 16'd3, "R7 cfg strobe", cfg_value, 3);
        check(n_send == s0 + 1 && last_len == 0, "R7 zlp", n_send, s0 + 1);
        pulse_in();
        idle(3);
        check(dev_addr == 7'h2A, "R7 addr unchanged", dev_addr, 42);
    endtask

    task automatic t_handoff_ack();
        int h0 = n_hand;
        int s0 = n_send;
        send_setup(8'h21, 8'h0A, 16'h0000, 16'h0001, 16'd0, 8);
        idle(3);
        check(n_hand == h0 + 1, "R8 handoff strobe", n_hand, h0 + 1);
        @(negedge clk);
        handoff_done = 1'b1;
        @(negedge clk);
        handoff_done = 1'b0;
        idle(3);
        check(n_send == s0 + 1 && last_len == 0 && ep_stall == 0, "R8 ack zlp", n_send, s0 + 1);
        pulse_in();
        idle(2);
    endtask

    task automatic t_handoff_timeout();
        int s0 = n_send;
        send_setup(8'h40, 8'h01, 16'h0000, 16'h0000, 16'd0, 8);
        idle(TMO - 6);
        check(ep_stall == 0, "R8 not yet timed out", ep_stall, 0);
        idle(12);
        check(ep_stall == 1, "R8 timeout stall", ep_stall, 1);
        check(n_send == s0, "R8 timeout no send", n_send, s0);
    endtask

    task automatic t_final_bus_reset();
        pulse_bus_reset();
        idle(2);
        check(dev_addr == 0 && addr_en == 1 && ep_stall == 0, "R9 reset clears", dev_addr, 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(2);
        t_reset_state();
        t_bus_reset();
        t_short_setup();
        t_desc_small();
        t_desc_trunc();
        t_desc_chunks();
        t_desc_miss();
        t_wrong_type_get();
        t_set_addr();
        t_set_cfg();
        t_handoff_ack();
        t_handoff_timeout();
        t_final_bus_reset();
        finish_run();
    end
endmodule